// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by reading a two-level page table that sits in physical memory, where no address translation applies. A 32-bit virtual address splits into a 10-bit first-level index, a 10-bit second-level index and a 12-bit page offset. The walker first reads the first-level entry at the address given by a software-written root pointer. That entry either names the page that holds the second-level table or marks the region as not present. The walker then reads the second-level (leaf) entry, checks the requested access against the leaf's rights and hands the mapping to the TLB for refill.

Only one walk is in flight at a time. The walk stops at the first entry that is not valid and reports a not-present fault for the original access. A leaf whose rights do not cover the access ends the walk with a protection fault. Memory is reached through a single read port that holds its request until the response arrives, so any latency is accepted. Software changes the root pointer on a process switch. A walk already under way keeps using the root it started with.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and after it is released, the outputs are miss_ready=1, mem_req_valid=0, walk_done=0 and walk_fault=0.
- R2: The first memory read of a walk addresses root + 4 × VA[31:22], where root is the value the root register held when the miss was accepted. A root write while a walk is running only affects later walks.
- R3: The second memory read addresses {first-level PPN, VA[21:12], 2'b00}.
- R4: A page table entry holds its valid bit at bit 0, read right at bit 1, write right at bit 2, execute right at bit 3 and the 20-bit PPN at bits 31:12. The other bits are ignored.
- R5: mem_req_valid stays high with a stable mem_req_addr until the cycle in which mem_rsp_valid is high. The response word is taken in that cycle, whatever the latency.
- R6: A first-level entry with valid=0 ends the walk with a not-present fault (fault_prot=0), and no second read is made.
- R7: A leaf entry with valid=0 ends the walk with a not-present fault (fault_prot=0).
- R8: The access code miss_acc selects the right that is needed: 0 is a load and needs read, 1 is a store and needs write, 2 or 3 is an instruction fetch and needs execute. A valid leaf without that right gives a fault with fault_prot=1.
- R9: A successful walk raises walk_done for exactly one cycle, in the cycle after the leaf response. In that cycle refill_vpn=VA[31:12], refill_ppn is the leaf PPN and refill_perm={X,W,R} of the leaf.
- R10: miss_ready is low from the cycle after a miss is accepted until the cycle after the result. A miss offered during that time is not taken.
- R11: A fault raises walk_fault for exactly one cycle, in the cycle after the response that caused it, with refill_vpn giving the faulting page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| root_we | input | 1 | Write strobe for the root pointer |
| root_wdata | input | 32 | New root pointer (byte address of first-level table) |
| miss_valid | input | 1 | A translation miss is offered |
| miss_ready | output | 1 | Walker is idle and takes the offered miss |
| miss_vaddr | input | 32 | Virtual address that missed |
| miss_acc | input | 2 | Access code: 0 load, 1 store, 2/3 fetch |
| mem_req_valid | output | 1 | Read request pending |
| mem_req_addr | output | 32 | Physical byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is present this cycle |
| mem_rsp_data | input | 32 | Entry word read from memory |
| walk_done | output | 1 | One-cycle pulse: refill outputs valid |
| walk_fault | output | 1 | One-cycle pulse: walk ended in a fault |
| fault_prot | output | 1 | With walk_fault: 1 protection, 0 not present |
| refill_vpn | output | 20 | Virtual page number of the walk |
| refill_ppn | output | 20 | Physical page number from the leaf |
| refill_perm | output | 3 | Leaf rights {execute, write, read} |

## Verification
The assertions assume that the memory port gives mem_rsp_valid only while a request is pending and that the word it returns belongs to the held address. The bench memory model meets this: it looks at the request at each falling edge, waits a chosen number of cycles and then presents a word for one cycle only. That word is computed from the requested address, so a wrong address leads to wrong data. The assertions also assume that root_we is never high in the cycle a miss is accepted. The bench changes the root only while idle or in the middle of a walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   // Entry bit positions shared by walker and rights checker
   localparam int BIT_VALID = 0;
   localparam int BIT_RD    = 1;
   localparam int BIT_WR    = 2;
   localparam int BIT_EX    = 3;

   typedef enum logic [1:0] {
      ACC_LOAD      = 2'd0,
      ACC_STORE     = 2'd1,
      ACC_FETCH     = 2'd2,
      ACC_FETCH_ALT = 2'd3
   } acc_e;

   typedef enum logic [2:0] {
      S_IDLE    = 3'd0,
      S_READ_L1 = 3'd1,
      S_READ_L2 = 3'd2,
      S_DONE    = 3'd3,
      S_FAULT   = 3'd4
   } walk_st_e;

   typedef struct packed {
      logic ex;
      logic wr;
      logic rd;
   } perm_t;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int PA_W  = 32,
   parameter int L1_W  = 10,
   parameter int L2_W  = 10,
   parameter int PPN_W = 20
) (
   input  logic [PA_W-1:0]  base,
   input  logic [L1_W-1:0]  l1_idx,
   input  logic [L2_W-1:0]  l2_idx,
   input  logic [PPN_W-1:0] tbl_ppn,
   output logic [PA_W-1:0]  l1_addr,
   output logic [PA_W-1:0]  l2_addr
);
   localparam int OFS_W = L1_W + 2;

   if (OFS_W > PA_W) begin : g_bad_ofs
      $error("first-level offset wider than physical address");
   end
   if (PPN_W + L2_W + 2 != PA_W) begin : g_bad_l2
      $error("second-level address fields do not fill the physical address");
   end

   logic [PA_W-1:0] l1_ofs;
   assign l1_ofs  = PA_W'({l1_idx, 2'b00});
   assign l1_addr = base + l1_ofs;
   assign l2_addr = {tbl_ppn, l2_idx, 2'b00};

endmodule

// File: rtl/ptw_perm_chk.sv
module ptw_perm_chk
   import ptw_pkg::*;
#(
   parameter bit LOAD_NEEDS_READ = 1'b1
) (
   input  acc_e  acc,
   input  perm_t perm,
   output logic  ok
);
   logic load_ok;

   if (LOAD_NEEDS_READ) begin : g_load_strict
      assign load_ok = perm.rd;
   end else begin : g_load_open
      assign load_ok = 1'b1;
   end

   always_comb begin
      unique case (acc)
         ACC_LOAD:  ok = load_ok;
         ACC_STORE: ok = perm.wr;
         default:   ok = perm.ex;
      endcase
   end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import ptw_pkg::*;
#(
   parameter int VA_W            = 32,
   parameter int PA_W            = 32,
   parameter int L1_W            = 10,
   parameter int L2_W            = 10,
   parameter int OFF_W           = 12,
   parameter int ENTRY_W         = 32,
   parameter bit LOAD_NEEDS_READ = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    root_we,
   input  logic [PA_W-1:0]         root_wdata,
   input  logic                    miss_valid,
   output logic                    miss_ready,
   input  logic [VA_W-1:0]         miss_vaddr,
   input  logic [1:0]              miss_acc,
   output logic                    mem_req_valid,
   output logic [PA_W-1:0]         mem_req_addr,
   input  logic                    mem_rsp_valid,
   input  logic [ENTRY_W-1:0]      mem_rsp_data,
   output logic                    walk_done,
   output logic                    walk_fault,
   output logic                    fault_prot,
   output logic [VA_W-OFF_W-1:0]   refill_vpn,
   output logic [PA_W-OFF_W-1:0]   refill_ppn,
   output logic [2:0]              refill_perm
);
   localparam int PPN_W = PA_W - OFF_W;
   localparam int VPN_W = VA_W - OFF_W;

   if (L1_W + L2_W + OFF_W != VA_W) begin : g_bad_split
      $error("virtual address split does not add up");
   end
   if (ENTRY_W < PPN_W + BIT_EX + 2) begin : g_bad_entry
      $error("entry too narrow for PPN and rights");
   end

   // ---------------- state ----------------
   walk_st_e        st_q;
   logic [PA_W-1:0] root_q, base_q;
   logic [VPN_W-1:0] vpn_q;
   acc_e            acc_q;
   logic [PPN_W-1:0] tbl_ppn_q, leaf_ppn_q;
   perm_t           leaf_perm_q;
   logic            prot_q;

   // ---------------- response fields (R4) ----------------
   logic            rsp_v;
   logic [PPN_W-1:0] rsp_ppn;
   perm_t           rsp_perm;
   logic            perm_ok;
   assign rsp_v    = mem_rsp_data[BIT_VALID];
   assign rsp_ppn  = mem_rsp_data[ENTRY_W-1 -: PPN_W];
   assign rsp_perm = perm_t'(mem_rsp_data[BIT_EX:BIT_RD]);

   logic unused_bits;
   assign unused_bits = ^{mem_rsp_data[ENTRY_W-PPN_W-1:BIT_EX+1], miss_vaddr[OFF_W-1:0]};

   // ---------------- address generation (R2, R3) ----------------
   logic [PA_W-1:0] l1_addr, l2_addr;
   ptw_addr_gen #(.PA_W(PA_W), .L1_W(L1_W), .L2_W(L2_W), .PPN_W(PPN_W)) u_addr (
      .base    (base_q),
      .l1_idx  (vpn_q[VPN_W-1 -: L1_W]),
      .l2_idx  (vpn_q[L2_W-1:0]),
      .tbl_ppn (tbl_ppn_q),
      .l1_addr (l1_addr),
      .l2_addr (l2_addr)
   );

   // ---------------- rights check (R8) ----------------
   ptw_perm_chk #(.LOAD_NEEDS_READ(LOAD_NEEDS_READ)) u_perm (
      .acc  (acc_q),
      .perm (rsp_perm),
      .ok   (perm_ok)
   );

   // ---------------- root register ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       root_q <= '0;
      else if (root_we) root_q <= root_wdata;
   end

   // ---------------- walk sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= S_IDLE;
         base_q      <= '0;
         vpn_q       <= '0;
         acc_q       <= ACC_LOAD;
         tbl_ppn_q   <= '0;
         leaf_ppn_q  <= '0;
         leaf_perm_q <= '0;
         prot_q      <= 1'b0;
      end else begin
         unique case (st_q)
            S_IDLE: begin
               if (miss_valid) begin
                  vpn_q  <= miss_vaddr[VA_W-1:OFF_W];
                  acc_q  <= acc_e'(miss_acc);
                  base_q <= root_q;
                  st_q   <= S_READ_L1;
               end
            end
            S_READ_L1: begin
               if (mem_rsp_valid) begin
                  if (!rsp_v) begin
                     prot_q <= 1'b0;
                     st_q   <= S_FAULT;
                  end else begin
                     tbl_ppn_q <= rsp_ppn;
                     st_q      <= S_READ_L2;
                  end
               end
            end
            S_READ_L2: begin
               if (mem_rsp_valid) begin
                  if (!rsp_v) begin
                     prot_q <= 1'b0;
                     st_q   <= S_FAULT;
                  end else if (!perm_ok) begin
                     prot_q <= 1'b1;
                     st_q   <= S_FAULT;
                  end else begin
                     leaf_ppn_q  <= rsp_ppn;
                     leaf_perm_q <= rsp_perm;
                     st_q        <= S_DONE;
                  end
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   // ---------------- outputs ----------------
   assign miss_ready    = (st_q == S_IDLE);
   assign mem_req_valid = (st_q == S_READ_L1) || (st_q == S_READ_L2);
   assign mem_req_addr  = (st_q == S_READ_L2) ? l2_addr : l1_addr;
   assign walk_done     = (st_q == S_DONE);
   assign walk_fault    = (st_q == S_FAULT);
   assign fault_prot    = walk_fault && prot_q;
   assign refill_vpn    = vpn_q;
   assign refill_ppn    = leaf_ppn_q;
   assign refill_perm   = leaf_perm_q;

   // ---------------- assertions ----------------
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      miss_ready |-> (!mem_req_valid && !walk_done && !walk_fault));

   a_r2_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && miss_ready && !root_we) |=>
      (mem_req_valid && mem_req_addr ==
         $past(root_q) + PA_W'({$past(miss_vaddr[VA_W-1 -: L1_W]), 2'b00})));

   a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

   a_r6_l1_absent: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_READ_L1 && mem_rsp_valid && !mem_rsp_data[BIT_VALID]) |=>
      (walk_fault && !fault_prot));

   a_r8_rights_held: assert property (@(posedge clk) disable iff (!rst_n)
      walk_done |-> ((acc_q == ACC_STORE) ? refill_perm[1] :
                     (acc_q[1] ? refill_perm[2] : (!LOAD_NEEDS_READ || refill_perm[0]))));

   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      walk_done |=> (!walk_done && miss_ready));

   a_r10_single_walk: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && miss_ready) |=> !miss_ready);

   a_r11_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      walk_fault |=> (!walk_fault && miss_ready));

   a_r9_done_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(walk_done && walk_fault));

endmodule

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;

   localparam logic [31:0] ROOT_A = 32'h0001_0000;
   localparam logic [31:0] ROOT_B = 32'h0002_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        root_we = 1'b0;
   logic [31:0] root_wdata = '0;
   logic        miss_valid = 1'b0;
   logic        miss_ready;
   logic [31:0] miss_vaddr = '0;
   logic [1:0]  miss_acc = '0;
   logic        mem_req_valid;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        walk_done, walk_fault, fault_prot;
   logic [19:0] refill_vpn, refill_ppn;
   logic [2:0]  refill_perm;

   int checks = 0;
   int fails  = 0;
   int mem_lat = 0;
   int wait_cnt = 0;
   int rd_cnt = 0;
   logic [31:0] seen_addr [2];
   logic [31:0] cur_root = '0;

   always #4 clk = ~clk;

   pt_walker u0 (
      .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_wdata(root_wdata),
      .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_vaddr(miss_vaddr),
      .miss_acc(miss_acc), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .walk_done(walk_done), .walk_fault(walk_fault), .fault_prot(fault_prot),
      .refill_vpn(refill_vpn), .refill_ppn(refill_ppn), .refill_perm(refill_perm)
   );

   // R4 entry layout used below: V bit0, R bit1, W bit2, X bit3, PPN bits 31:12
   function automatic logic [31:0] l1_entry(input logic [31:0] root, input int i);
      logic v;
      int   p;
      if (root == ROOT_A) begin
         v = (i % 4) != 3;
         p = 'h100 + i;
      end else begin
         v = (i % 3) != 2;
         p = 'h600 + i;
      end
      return {p[19:0], 11'h0, v};
   endfunction

   function automatic logic [31:0] l2_entry(input int p, input int j);
      logic v;
      int   pm, q;
      v  = ((p + j) % 5) != 4;
      pm = (p ^ j) & 7;
      q  = (p * 3 + j) & 'hFFFFF;
      return {q[19:0], 8'h0, pm[2:0], v};
   endfunction

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      if (a[31:12] == ROOT_A[31:12]) return l1_entry(ROOT_A, int'(a[11:2]));
      if (a[31:12] == ROOT_B[31:12]) return l1_entry(ROOT_B, int'(a[11:2]));
      return l2_entry(int'(a[31:12]), int'(a[11:2]));
   endfunction

   // memory model: responds after mem_lat waiting cycles, for one cycle
   always @(negedge clk) begin
      mem_rsp_valid = 1'b0;
      if (mem_req_valid) begin
         if (wait_cnt >= mem_lat) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem_word(mem_req_addr);
            if (rd_cnt < 2) seen_addr[rd_cnt] = mem_req_addr;
            rd_cnt   = rd_cnt + 1;
            wait_cnt = 0;
         end else begin
            wait_cnt = wait_cnt + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic walk(input logic [31:0] va, input logic [1:0] acc, input int lat,
                       input bit busy_offer, input bit mid_root);
      int i, j, p, reads, n, need;
      logic [31:0] e1, e2, a1, a2;
      bit exp_fault, exp_prot;
      logic [2:0] pm;
      i  = int'(va[31:22]);
      j  = int'(va[21:12]);
      a1 = cur_root + 32'(i * 4);
      e1 = l1_entry(cur_root, i);
      p  = int'(e1[31:12]);
      a2 = {e1[31:12], va[21:12], 2'b00};
      e2 = l2_entry(p, j);
      pm = e2[3:1];
      need = (acc == 2'd0) ? 0 : (acc == 2'd1) ? 1 : 2;
      exp_prot = 1'b0;
      if (!e1[0]) begin
         reads = 1; exp_fault = 1'b1;
      end else if (!e2[0]) begin
         reads = 2; exp_fault = 1'b1;
      end else begin
         reads = 2; exp_fault = !pm[need]; exp_prot = exp_fault;
      end

      @(negedge clk);
      mem_lat = lat; wait_cnt = 0; rd_cnt = 0;
      miss_valid = 1'b1; miss_vaddr = va; miss_acc = acc;
      @(negedge clk);
      if (busy_offer) begin
         miss_vaddr = ~va; miss_acc = 2'd1;
      end else begin
         miss_valid = 1'b0;
      end
      n = 1;
      forever begin
         if (mid_root && n == 1) begin root_we = 1'b1; root_wdata = ROOT_B; end
         if (mid_root && n == 2) root_we = 1'b0;
         chk(!miss_ready, "R10", "ready low during walk", 64'(miss_ready), 0);
         if (walk_done || walk_fault || n > 60) break;
         @(negedge clk);
         n++;
      end
      miss_valid = 1'b0;
      root_we = 1'b0;
      if (mid_root) cur_root = ROOT_B;

      chk(walk_fault == exp_fault && walk_done == !exp_fault,
          exp_fault ? (reads == 1 ? "R6" : (exp_prot ? "R8" : "R7")) : "R9",
          "result kind", {walk_done, walk_fault}, {!exp_fault, exp_fault});
      chk(n == reads * (lat + 1) + 1, exp_fault ? "R11" : "R5", "result cycle", n,
          reads * (lat + 1) + 1);
      chk(rd_cnt == reads, "R6", "number of reads", rd_cnt, reads);
      chk(seen_addr[0] == a1, "R2", "first read address", seen_addr[0], a1);
      if (reads == 2) chk(seen_addr[1] == a2, "R3", "second read address", seen_addr[1], a2);
      chk(refill_vpn == va[31:12], "R9", "refill vpn", refill_vpn, va[31:12]);
      if (exp_fault) begin
         chk(fault_prot == exp_prot, "R8", "fault kind", fault_prot, exp_prot);
      end else begin
         chk(refill_ppn == e2[31:12], "R4", "refill ppn", refill_ppn, e2[31:12]);
         chk(refill_perm == pm, "R4", "refill rights", refill_perm, pm);
      end
      @(negedge clk);
      chk(!walk_done && !walk_fault && miss_ready, exp_fault ? "R11" : "R9",
          "single-cycle result", {walk_done, walk_fault, miss_ready}, 3'b001);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "R10", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: values while reset is held
      chk(miss_ready && !mem_req_valid && !walk_done && !walk_fault, "R1", "in reset",
          {miss_ready, mem_req_valid, walk_done, walk_fault}, 4'b1000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(miss_ready && !mem_req_valid && !walk_done && !walk_fault, "R1", "after reset",
          {miss_ready, mem_req_valid, walk_done, walk_fault}, 4'b1000);

      root_we = 1'b1; root_wdata = ROOT_A;
      @(negedge clk);
      root_we = 1'b0; cur_root = ROOT_A;

      // sweep over first index, second index, access code and latency
      for (int ii = 0; ii < 14; ii++) begin
         for (int jj = 0; jj < 5; jj++) begin
            for (int aa = 0; aa < 4; aa++) begin
               int idx;
               idx = (ii == 12) ? 1023 : (ii == 13) ? 512 : ii;
               walk({idx[9:0], jj[9:0], 12'hABC}, aa[1:0], (ii + jj + aa) % 3, 1'b0, 1'b0);
            end
         end
      end

      // R10: a second miss held during a walk is not taken by it
      walk({10'd5, 10'd2, 12'h0}, 2'd0, 2, 1'b1, 1'b0);

      // R2: root changed during a walk, walk keeps old root; next walks use new one
      walk({10'd4, 10'd1, 12'h0}, 2'd2, 1, 1'b0, 1'b1);
      for (int ii = 0; ii < 6; ii++) begin
         for (int jj = 0; jj < 3; jj++) begin
            for (int aa = 0; aa < 3; aa++) begin
               walk({ii[9:0], jj[9:0], 12'h004}, aa[1:0], (ii + aa) % 4, 1'b0, 1'b0);
            end
         end
      end
      finish_run();
   end

endmodule